// File: doc/BRIEF.md
# Symbol Clock Fan-Out Enable Manager

This block holds the clock-enable control bits for four link back ends and four stream front ends. Each front end has an enable bit and a source select that names the back end whose symbol clock it uses. Several front ends may share one back end, as a multi-stream link does. The block therefore keeps a back end running while any enabled front end still points at it.

Commands arrive as one-cycle strobes, each with an enable/disable flag, a stream index and a link index. An enable turns on the back end and then attaches the front end to it. A disable detaches the front end first. One cycle later, the block counts the front ends that still select that link and stops the back end only if none remain. A mode input asks the block to also set root-gate-disable bits when it enables. The per-link user counts are brought out. The block drives control bits only; the gating cells sit elsewhere.

Top module: `symclk_fanout`

## Requirements
- R1: After reset, all back-end and front-end enables, selects, root-gate-disable bits and user counts are 0, and `cmdReady` is 1.
- R2: An accepted enable with stream s and link l (both below 4) sets `beEnable[l]` and `feEnable[s]` at the next clock edge, and sets select field s (`feSelect[2s+1:2s]`) to l.
- R3: An accepted disable with stream s below 4 clears `feEnable[s]` and its select field to 0 at the next clock edge. A front end that is not enabled always reads select 0.
- R4: After an accepted disable, `cmdReady` is 0 for exactly one cycle. A command presented in that cycle is ignored.
- R5: On the second edge of a disable, `beEnable[l]` clears when no enabled front end selects l. Before that edge the back end stays on, and a back end never clears at any other time.
- R6: A back end stays enabled while at least one enabled front end still selects it. Every enabled front end selects an enabled back end.
- R7: With `optMode` = 1, an enable also sets `beRootGateDis[l]` and `feRootGateDis[s]`. With `optMode` = 0, an enable leaves both vectors unchanged.
- R8: Root-gate-disable bits, once set, stay set until reset. A disable never clears them.
- R9: An enable whose link index is 4 or above changes no output.
- R10: A stream index of 4 or above leaves every front end untouched. An enable with such a stream still sets the back end for a valid link. A disable with such a stream still performs the back-end evaluation for the link.
- R11: `beUserCount` field l (3 bits at `[3l+2:3l]`) equals the number of enabled front ends whose select is l.
- R12: A disable whose link index is 4 or above clears the front end but changes no back-end enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| optMode | input | 1 | When 1, enables also set the root-gate-disable bits |
| cmdValid | input | 1 | Command strobe |
| cmdEnable | input | 1 | 1 = enable command, 0 = disable command |
| cmdStream | input | 3 | Front-end (stream) index; values 4..7 are out of range |
| cmdLink | input | 3 | Back-end (link) index; values 4..7 are out of range |
| cmdReady | output | 1 | 0 during the back-end evaluation cycle of a disable |
| beEnable | output | 4 | Back-end clock enables |
| feEnable | output | 4 | Front-end clock enables |
| feSelect | output | 8 | 2-bit source select per front end |
| beRootGateDis | output | 4 | Back-end root-gate-disable bits |
| feRootGateDis | output | 4 | Front-end root-gate-disable bits |
| beUserCount | output | 12 | 3-bit count per back end of enabled front ends selecting it |

## Verification
The main corner case is a shared link: two streams on one back end, disabled one at a time. A design that skipped the count would stop the clock under the surviving stream. A design that counted before clearing the front end would leave the back end on after the last stream left.

The bench also checks the edge-by-edge timing of the two-cycle disable. It sends a command into the busy cycle, which a design without the hold-off would act on. It drives out-of-range stream and link indices, which a design decoding only the low bits would alias onto real instances. It also checks that root-gate bits survive a disable.

// File: rtl/symclk_pkg.sv
package symclk_pkg;
  localparam int NUM_INST = 4;
  localparam int SEL_W    = $clog2(NUM_INST);
  localparam int IDX_W    = SEL_W + 1;
  localparam int CNT_W    = $clog2(NUM_INST + 1);

  typedef struct packed {
    logic             setBe;
    logic             setFe;
    logic             setGate;
    logic             clrFe;
    logic             evalBe;
    logic [IDX_W-1:0] stream;
    logic [IDX_W-1:0] link;
  } strobe_t;
endpackage

// File: rtl/symclk_ctrl.sv
module symclk_ctrl
  import symclk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             optMode,
  input  logic             cmdValid,
  input  logic             cmdEnable,
  input  logic [IDX_W-1:0] cmdStream,
  input  logic [IDX_W-1:0] cmdLink,
  output logic             cmdReady,
  output strobe_t          str
);
  logic             pending;
  logic [IDX_W-1:0] pendLink;
  logic             accept;

  assign accept   = cmdValid && !pending;
  assign cmdReady = !pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b0;
      pendLink <= '0;
    end else begin
      pending <= accept && !cmdEnable;
      if (accept && !cmdEnable) pendLink <= cmdLink;
    end
  end

  always_comb begin
    str.setBe   = accept && cmdEnable;
    str.setFe   = accept && cmdEnable;
    str.setGate = accept && cmdEnable && optMode;
    str.clrFe   = accept && !cmdEnable;
    str.evalBe  = pending;
    str.stream  = cmdStream;
    str.link    = pending ? pendLink : cmdLink;
  end

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReady |=> cmdReady); // R4
  AST_DIS_THEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && !cmdEnable) |=> !cmdReady); // R4
endmodule

// File: rtl/symclk_dp.sv
module symclk_dp
  import symclk_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   str,
  output logic [NUM_INST-1:0]       beEnable,
  output logic [NUM_INST-1:0]       feEnable,
  output logic [NUM_INST*SEL_W-1:0] feSelect,
  output logic [NUM_INST-1:0]       beRootGateDis,
  output logic [NUM_INST-1:0]       feRootGateDis,
  output logic [NUM_INST*CNT_W-1:0] beUserCount
);
  logic [NUM_INST-1:0] beEn, feEn, beGate, feGate;
  logic [SEL_W-1:0]    feSel   [NUM_INST];
  logic [CNT_W-1:0]    userCnt [NUM_INST];
  logic                linkOk;

  assign linkOk = str.link < IDX_W'(NUM_INST);

  // per-back-end count of enabled front ends that select it
  for (genvar b = 0; b < NUM_INST; b++) begin : g_count
    always_comb begin
      userCnt[b] = '0;
      for (int f = 0; f < NUM_INST; f++)
        userCnt[b] = userCnt[b] + CNT_W'(feEn[f] && (feSel[f] == SEL_W'(b)));
    end
    assign beUserCount[b*CNT_W +: CNT_W] = userCnt[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beEn   <= '0;
      feEn   <= '0;
      beGate <= '0;
      feGate <= '0;
      for (int i = 0; i < NUM_INST; i++) feSel[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_INST; i++) begin
        if (str.setBe && str.link == IDX_W'(i)) beEn[i] <= 1'b1;
        else if (str.evalBe && str.link == IDX_W'(i) && userCnt[i] == '0) beEn[i] <= 1'b0;
        if (str.setGate && str.link == IDX_W'(i)) beGate[i] <= 1'b1;
        if (str.setFe && linkOk && str.stream == IDX_W'(i)) begin
          feEn[i]  <= 1'b1;
          feSel[i] <= str.link[SEL_W-1:0];
          if (str.setGate) feGate[i] <= 1'b1;
        end else if (str.clrFe && str.stream == IDX_W'(i)) begin
          feEn[i]  <= 1'b0;
          feSel[i] <= '0;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_INST; i++) begin : g_out
    assign feSelect[i*SEL_W +: SEL_W] = feSel[i];

    AST_BE_FALL_ON_EVAL: assert property (@(posedge clk) disable iff (!rstN)
      $fell(beEn[i]) |-> $past(str.evalBe)); // R5
    AST_BE_FALL_NO_USER: assert property (@(posedge clk) disable iff (!rstN)
      $fell(beEn[i]) |-> userCnt[i] == '0); // R6
    AST_FE_IDLE_SEL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !feEn[i] |-> feSel[i] == '0); // R3
    AST_FE_NEEDS_BE: assert property (@(posedge clk) disable iff (!rstN)
      feEn[i] |-> beEn[feSel[i]]); // R6
    AST_BE_GATE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      beGate[i] |=> beGate[i]); // R8
    AST_FE_GATE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      feGate[i] |=> feGate[i]); // R8
  end

  assign beEnable      = beEn;
  assign feEnable      = feEn;
  assign beRootGateDis = beGate;
  assign feRootGateDis = feGate;
endmodule

// File: rtl/symclk_fanout.sv
module symclk_fanout
  import symclk_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      optMode,
  input  logic                      cmdValid,
  input  logic                      cmdEnable,
  input  logic [IDX_W-1:0]          cmdStream,
  input  logic [IDX_W-1:0]          cmdLink,
  output logic                      cmdReady,
  output logic [NUM_INST-1:0]       beEnable,
  output logic [NUM_INST-1:0]       feEnable,
  output logic [NUM_INST*SEL_W-1:0] feSelect,
  output logic [NUM_INST-1:0]       beRootGateDis,
  output logic [NUM_INST-1:0]       feRootGateDis,
  output logic [NUM_INST*CNT_W-1:0] beUserCount
);
  strobe_t str;

  symclk_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .optMode(optMode), .cmdValid(cmdValid),
    .cmdEnable(cmdEnable), .cmdStream(cmdStream), .cmdLink(cmdLink),
    .cmdReady(cmdReady), .str(str)
  );

  symclk_dp i_dp (
    .clk(clk), .rstN(rstN), .str(str), .beEnable(beEnable),
    .feEnable(feEnable), .feSelect(feSelect), .beRootGateDis(beRootGateDis),
    .feRootGateDis(feRootGateDis), .beUserCount(beUserCount)
  );
endmodule

// File: tb/test_symclk_fanout.sv
module test_symclk_fanout;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        optMode = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdEnable = 1'b0;
  logic [2:0]  cmdStream = '0;
  logic [2:0]  cmdLink = '0;
  logic        cmdReady;
  logic [3:0]  beEnable, feEnable, beRootGateDis, feRootGateDis;
  logic [7:0]  feSelect;
  logic [11:0] beUserCount;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  symclk_fanout i_symclk_fanout (
    .clk(clk), .rstN(rstN), .optMode(optMode), .cmdValid(cmdValid),
    .cmdEnable(cmdEnable), .cmdStream(cmdStream), .cmdLink(cmdLink),
    .cmdReady(cmdReady), .beEnable(beEnable), .feEnable(feEnable),
    .feSelect(feSelect), .beRootGateDis(beRootGateDis),
    .feRootGateDis(feRootGateDis), .beUserCount(beUserCount)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // present one command for one edge; returns at the following falling edge
  task automatic issue(bit en, logic [2:0] s, logic [2:0] l);
    @(negedge clk);
    cmdValid = 1'b1; cmdEnable = en; cmdStream = s; cmdLink = l;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic stepCycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 beEnable", beEnable, 0);
    check("R1 feEnable", feEnable, 0);
    check("R1 feSelect", feSelect, 0);
    check("R1 gates", {beRootGateDis, feRootGateDis}, 0);
    check("R1 beUserCount", beUserCount, 0);
    check("R1 cmdReady", cmdReady, 1);
  endtask

  task automatic t_enable();
    issue(1'b1, 3'd1, 3'd2);
    check("R2 beEnable", beEnable, 4'b0100);
    check("R2 feEnable", feEnable, 4'b0010);
    check("R2 feSelect", feSelect, 8'h08);
    check("R7 gates untouched with mode off", {beRootGateDis, feRootGateDis}, 0);
    check("R11 count one user", beUserCount, 12'h040);
  endtask

  task automatic t_shared();
    issue(1'b1, 3'd3, 3'd2);
    check("R11 count two users", beUserCount, 12'h080);
    check("R2 second select", feSelect, 8'h88);
    issue(1'b0, 3'd1, 3'd2);
    check("R3 fe cleared", feEnable, 4'b1000);
    check("R3 select cleared", feSelect, 8'h80);
    check("R4 busy after disable", cmdReady, 0);
    stepCycle();
    check("R6 shared link kept", beEnable, 4'b0100);
    check("R4 ready again", cmdReady, 1);
    issue(1'b0, 3'd3, 3'd2);
    check("R5 still on before eval edge", beEnable, 4'b0100);
    stepCycle();
    check("R5 last user gone", beEnable, 4'b0000);
    check("R11 count zero", beUserCount, 0);
  endtask

  task automatic t_busyIgnore();
    issue(1'b1, 3'd0, 3'd0);
    check("R2 enable s0 l0", {beEnable, feEnable}, 8'h11);
    @(negedge clk);
    cmdValid = 1'b1; cmdEnable = 1'b0; cmdStream = 3'd0; cmdLink = 3'd0;
    @(posedge clk);
    @(negedge clk);
    cmdEnable = 1'b1; cmdStream = 3'd2; cmdLink = 3'd1;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    check("R4 busy command ignored be", beEnable, 0);
    check("R4 busy command ignored fe", feEnable, 0);
  endtask

  task automatic t_gate();
    optMode = 1'b1;
    issue(1'b1, 3'd2, 3'd3);
    check("R7 be gate", beRootGateDis, 4'b1000);
    check("R7 fe gate", feRootGateDis, 4'b0100);
    optMode = 1'b0;
    issue(1'b0, 3'd2, 3'd3);
    stepCycle();
    check("R5 be off", beEnable, 0);
    check("R8 gates kept", {beRootGateDis, feRootGateDis}, 8'h84);
  endtask

  task automatic t_range();
    issue(1'b1, 3'd0, 3'd5);
    check("R9 bad link enable", {beEnable, feEnable, feSelect}, 0);
    issue(1'b1, 3'd6, 3'd1);
    check("R10 bad stream enable be", beEnable, 4'b0010);
    check("R10 bad stream enable fe", feEnable, 0);
    issue(1'b0, 3'd6, 3'd1);
    stepCycle();
    check("R10 bad stream disable evaluates", beEnable, 0);
    issue(1'b1, 3'd1, 3'd0);
    issue(1'b0, 3'd1, 3'd7);
    check("R12 fe cleared", feEnable, 0);
    stepCycle();
    check("R12 be unchanged", beEnable, 4'b0001);
    issue(1'b0, 3'd6, 3'd0);
    stepCycle();
    check("R10 cleanup eval", beEnable, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_shared();
    t_busyIgnore();
    t_gate();
    t_range();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule